// File: doc/BRIEF.md
# Sampled Majority-Vote Glitch Filter

This block cleans up a noisy single-bit comparator decision before it can cause a protective trip. The raw bit is brought into the clock domain through a two-stage synchronizer. A programmable prescaler then picks it up once every `prescale + 1` clock cycles and pushes it into a shift window. A programmable length selects how many of the newest window entries take part in the vote.

The filtered output moves to a new level only when enough samples agree with that level. It goes high once the number of ones reaches the threshold, goes low once the number of zeros reaches it, and keeps its value in every other case. A threshold above half the window gives hysteresis, and pulses shorter than the threshold never reach the output. A typical setting is prescale 20, window field 30 and threshold 18. An init strobe fills every window slot with the current synchronized level, so the filter starts settled rather than from a window of zeros.

Top module: `trip_vote_filter`

## Requirements
- R1: The raw input passes through two synchronizer flops before it is sampled. With prescale 0, window field 0 and threshold 1, a rising raw input drives the output high on the fourth rising clock edge after the change, and not before.
- R2: While out of reset, a sample is taken once every `prescale + 1` cycles, where prescale is 10 bits wide (0 to 1023). The window does not change between samples.
- R3: The window field `winLen` is 5 bits wide (0 to 31), and the vote counts only the newest `winLen + 1` samples. Older entries still held in the 32-slot store have no effect on the output.
- R4: On each clock edge the output becomes 1 when the count of ones among the counted samples is at least `thresh`. This rule takes priority over R5, so a threshold of 0 forces the output high.
- R5: Otherwise the output becomes 0 when the count of zeros (`winLen + 1` minus the ones) is at least `thresh`.
- R6: When neither count reaches the threshold, the output keeps its value. A run of opposite samples shorter than the threshold therefore never shows at the output.
- R7: A high `initStrobe` in a cycle loads all 32 slots with the synchronized level. It takes precedence over a sample due in the same cycle, and the output follows on the next edge.
- R8: Reset is synchronous and active low. It clears the output, the window and the synchronizer, and loads the prescale counter with `prescale`. The first sample after release is therefore taken on edge `prescale + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rawIn | input | 1 | Unfiltered comparator bit, asynchronous |
| prescale | input | 10 | Sample period minus one, in clock cycles |
| winLen | input | 5 | Counted window length minus one |
| thresh | input | 5 | Number of agreeing samples needed to change the output |
| initStrobe | input | 1 | Fill every window slot with the synchronized level |
| filtOut | output | 1 | Filtered bit |

## Verification
The main function is driven with single pulses of chosen width into a window that starts settled low. Pulses one short of the threshold and pulses exactly at the threshold separate the rising rule from the hold rule, and pulses longer than the window show that only the counted window limits the vote. Reset-to-output latencies are measured at two thresholds and two prescale values: the absolute latency checks the counter reload, and the difference between thresholds checks the sample period. Directed cases cover the high-side hold, a threshold of 0, the full 32-sample window, old ones beyond a short window, the init fill, and the four-edge synchronizer latency.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  typedef struct packed {
    logic sample;
    logic load;
  } filtStrobe_t;
endpackage

// File: rtl/tvf_ctrl.sv
module tvf_ctrl
  import tvf_pkg::*;
#(
  parameter int PRESCALE_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rawIn,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  initStrobe,
  output filtStrobe_t           strobes,
  output logic                  syncBit
);
  logic [1:0]            syncPipe;
  logic [PRESCALE_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[0], rawIn};
  end
  assign syncBit = syncPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN)              tickCnt <= prescale;
    else if (tickCnt == '0) tickCnt <= prescale;
    else                    tickCnt <= tickCnt - 1'b1;
  end

  always_comb begin
    strobes.sample = (tickCnt == '0);
    strobes.load   = initStrobe;
  end

  // R2
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> tickCnt == $past(prescale));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sample |=> tickCnt == $past(tickCnt) - 1'b1);
endmodule

// File: rtl/tvf_datapath.sv
module tvf_datapath
  import tvf_pkg::*;
#(
  parameter int WIN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  filtStrobe_t      strobes,
  input  logic             syncBit,
  input  logic [WIN_W-1:0] winLen,
  input  logic [WIN_W-1:0] thresh,
  output logic             filtOut
);
  localparam int SLOTS = 1 << WIN_W;
  localparam int CNT_W = WIN_W + 1;

  logic [SLOTS-1:0] window;
  logic [SLOTS-1:0] slotMask;
  logic [CNT_W-1:0] onesCnt;
  logic [CNT_W-1:0] zerosCnt;
  logic [CNT_W-1:0] threshExt;
  logic             goHigh;
  logic             goLow;

  always_ff @(posedge clk) begin
    if (!rstN)               window <= '0;
    else if (strobes.load)   window <= {SLOTS{syncBit}};
    else if (strobes.sample) window <= {window[SLOTS-2:0], syncBit};
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_mask
    assign slotMask[g] = (g <= int'(winLen));
  end

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      onesCnt = onesCnt + CNT_W'(window[i] & slotMask[i]);
    end
  end

  assign zerosCnt  = CNT_W'(winLen) + CNT_W'(1) - onesCnt;
  assign threshExt = CNT_W'(thresh);
  assign goHigh    = onesCnt >= threshExt;
  assign goLow     = zerosCnt >= threshExt;

  always_ff @(posedge clk) begin
    if (!rstN)      filtOut <= 1'b0;
    else if (goHigh) filtOut <= 1'b1;
    else if (goLow)  filtOut <= 1'b0;
  end

  // R2
  window_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.sample && !strobes.load) |=> $stable(window));
  // R7
  init_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> window == {SLOTS{$past(syncBit)}});
  // R4
  rise_vote_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtOut) |-> $past(onesCnt) >= $past(threshExt));
  // R5
  fall_vote_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(filtOut) |-> ($past(zerosCnt) >= $past(threshExt)) && ($past(onesCnt) < $past(threshExt)));
endmodule

// File: rtl/trip_vote_filter.sv
module trip_vote_filter
  import tvf_pkg::*;
#(
  parameter int PRESCALE_W = 10,
  parameter int WIN_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rawIn,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic [WIN_W-1:0]      winLen,
  input  logic [WIN_W-1:0]      thresh,
  input  logic                  initStrobe,
  output logic                  filtOut
);
  filtStrobe_t strobes;
  logic        syncBit;

  tvf_ctrl #(.PRESCALE_W(PRESCALE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .prescale  (prescale),
    .initStrobe(initStrobe),
    .strobes   (strobes),
    .syncBit   (syncBit)
  );

  tvf_datapath #(.WIN_W(WIN_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .syncBit(syncBit),
    .winLen (winLen),
    .thresh (thresh),
    .filtOut(filtOut)
  );
endmodule

// File: tb/tb_trip_vote_filter.sv
module tb_trip_vote_filter;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0] w;
    logic [4:0] t;
    logic [5:0] p;
    logic       e;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t ROWS [NROWS] = '{
    '{5'd3,  5'd3,  6'd2,  1'b0},
    '{5'd3,  5'd3,  6'd3,  1'b1},
    '{5'd7,  5'd5,  6'd4,  1'b0},
    '{5'd7,  5'd5,  6'd5,  1'b1},
    '{5'd30, 5'd18, 6'd17, 1'b0},
    '{5'd30, 5'd18, 6'd18, 1'b1},
    '{5'd31, 5'd31, 6'd30, 1'b0},
    '{5'd31, 5'd31, 6'd40, 1'b1},
    '{5'd0,  5'd1,  6'd1,  1'b1},
    '{5'd3,  5'd3,  6'd20, 1'b1},
    '{5'd4,  5'd3,  6'd2,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b0;
  logic [9:0] prescale = 10'd0;
  logic [4:0] winLen = 5'd0;
  logic [4:0] thresh = 5'd1;
  logic       initStrobe = 1'b0;
  logic       filtOut;

  int checks = 0;
  int errors = 0;

  trip_vote_filter dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .prescale(prescale),
    .winLen(winLen), .thresh(thresh), .initStrobe(initStrobe), .filtOut(filtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic level);
    rawIn = level;
    repeat (3) @(negedge clk);
    initStrobe = 1'b1;
    @(negedge clk);
    initStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic measureRise(input int p, input int w, input int t, output int n);
    @(negedge clk);
    rstN = 1'b0; prescale = 10'(p); winLen = 5'(w); thresh = 5'(t); rawIn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (filtOut) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nA, nB;
    bit sawHigh, sawLow;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(filtOut == 1'b0, "R8 reset output", int'(filtOut), 0);
    rstN = 1'b1;

    // R4 R5 R6 R3: pulse table, prescale 0, window settled low
    for (int r = 0; r < NROWS; r++) begin
      prescale = 10'd0; winLen = ROWS[r].w; thresh = ROWS[r].t;
      settle(1'b0);
      check(filtOut == 1'b0, "R5 settled low", int'(filtOut), 0);
      sawHigh = 1'b0;
      rawIn = 1'b1;
      repeat (int'(ROWS[r].p)) begin
        @(negedge clk);
        sawHigh |= filtOut;
      end
      rawIn = 1'b0;
      repeat (45) begin
        @(negedge clk);
        sawHigh |= filtOut;
      end
      check(sawHigh == ROWS[r].e, "R4/R6 pulse vote", int'(sawHigh), int'(ROWS[r].e));
      check(filtOut == 1'b0, "R5 return low", int'(filtOut), 0);
    end

    // R1 synchronizer latency: four edges
    prescale = 10'd0; winLen = 5'd0; thresh = 5'd1;
    settle(1'b0);
    rawIn = 1'b1;
    repeat (3) @(negedge clk);
    check(filtOut == 1'b0, "R1 not before edge 4", int'(filtOut), 0);
    @(negedge clk);
    check(filtOut == 1'b1, "R1 high at edge 4", int'(filtOut), 1);

    // R6 high-side hold: short low run does not drop the output
    winLen = 5'd3; thresh = 5'd3;
    settle(1'b1);
    check(filtOut == 1'b1, "R7 settled high", int'(filtOut), 1);
    sawLow = 1'b0;
    rawIn = 1'b0;
    repeat (2) begin @(negedge clk); sawLow |= !filtOut; end
    rawIn = 1'b1;
    repeat (10) begin @(negedge clk); sawLow |= !filtOut; end
    check(sawLow == 1'b0, "R6 hold high", int'(sawLow), 0);

    // R3 old ones beyond the short window are ignored
    rawIn = 1'b0;
    repeat (8) @(negedge clk);
    check(filtOut == 1'b0, "R3 old slots ignored", int'(filtOut), 1'b0);

    // R4 threshold 0: ones rule wins
    winLen = 5'd3; thresh = 5'd4;
    settle(1'b0);
    check(filtOut == 1'b0, "R4 pre threshold 0", int'(filtOut), 0);
    thresh = 5'd0;
    @(negedge clk);
    check(filtOut == 1'b1, "R4 threshold 0 forces high", int'(filtOut), 1);

    // R7 init fill with typical settings, before the first sample
    @(negedge clk);
    rstN = 1'b0; prescale = 10'd20; winLen = 5'd30; thresh = 5'd18; rawIn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    initStrobe = 1'b1;
    @(negedge clk);
    initStrobe = 1'b0;
    check(filtOut == 1'b0, "R7 one edge after load", int'(filtOut), 0);
    @(negedge clk);
    check(filtOut == 1'b1, "R7 output follows fill", int'(filtOut), 1);

    // R8 reset clears a high output
    rstN = 1'b0;
    @(negedge clk);
    check(filtOut == 1'b0, "R8 reset clears", int'(filtOut), 0);

    // R2 R8 sample period and counter reload
    measureRise(4, 3, 1, nA);
    check(nA == 6, "R8 first sample at edge p+1", nA, 6);
    measureRise(4, 3, 4, nB);
    check(nB - nA == 15, "R2 period prescale 4", nB - nA, 15);
    measureRise(1023, 3, 1, nA);
    check(nA == 1025, "R8 reload prescale 1023", nA, 1025);
    measureRise(1023, 3, 4, nB);
    check(nB - nA == 3072, "R2 period prescale 1023", nB - nA, 3072);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule